// File: doc/BRIEF.md
# Write-one-to-clear interrupt status unit

This block gathers single-cycle condition strobes from a serial controller's transmit FIFO, receive FIFO, end-of-transfer logic and bus-access checker into one sticky status register. Each strobe sets a status bit at a fixed position, and the bit holds until software writes a one to it through the clear port. A strobe that is still being driven sets its bit again at once, so software can learn the present state of a FIFO by clearing a bit and reading it back.

An enable mask selects the status bits that may raise the interrupt. The interrupt output is level-high and is the OR of status AND enable. The mask is zero after reset. Software normally enables only the illegal-access source and polls the rest. A synchronous soft clear input empties both the status and the mask.

Top module: `isu_top`

## Requirements
- R1: Each strobe sets its own status bit one clock after it is sampled high. The positions are: tx_evt_i[0] trigger→0, tx_evt_i[1] empty→1, tx_evt_i[2] half full→2, tx_evt_i[3] full→3, rx_evt_i[0] trigger→5, rx_evt_i[1] word available→6, rx_evt_i[2] half full→7, rx_evt_i[3] full→8, rx_evt_i[4] byte available→11, done_evt_i→9, acc_err_evt_i→12.
- R2: A set status bit stays set while no clear write and no soft clear touches it.
- R3: A clear write clears every status bit whose clr_data_i bit is 1, one clock later, unless that bit's strobe is also high.
- R4: Status bits whose clr_data_i bit is 0 are left unchanged by a clear write.
- R5: When a strobe and a clear write for the same bit land in the same cycle, the bit is set afterwards.
- R6: While a strobe is held high, its status bit reads 1 after every clear write.
- R7: Bits 10 and 4 of status_o and enable_o always read 0.
- R8: An enable write loads en_data_i into the mask one clock later, and enable_o returns it with bits 10 and 4 at 0.
- R9: irq_o is 1 exactly when some bit is set in both status_o and enable_o, in the same cycle.
- R10: After rst_n, status_o, enable_o and irq_o are all 0.
- R11: soft_clr_i clears status and mask on the next clock. This takes priority over strobes and writes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_clr_i | input | 1 | Synchronous clear of status and mask |
| tx_evt_i | input | 4 | Transmit FIFO strobes: trigger, empty, half, full |
| rx_evt_i | input | 5 | Receive FIFO strobes: trigger, word, half, full, byte |
| done_evt_i | input | 1 | Transfer complete strobe |
| acc_err_evt_i | input | 1 | Illegal register access strobe |
| clr_wr_i | input | 1 | Clear write strobe |
| clr_data_i | input | 13 | Write-one-to-clear bits |
| en_wr_i | input | 1 | Enable mask write strobe |
| en_data_i | input | 13 | New enable mask |
| status_o | output | 13 | Status register read value |
| enable_o | output | 13 | Enable mask read value |
| irq_o | output | 1 | Level-high interrupt |

## Verification
Assertions check on every cycle that status bits are sticky, that clear writes remove only unset-by-event bits, that a strobe always wins over a clear, that soft clear empties both registers, that mask writes land, and that reserved bits stay at zero. The scenarios alone show the bit-position mapping of each source, the clear-and-read-back behaviour of a held condition, the masking of the interrupt under changing enables, and the values left after reset.

// File: rtl/isu_pkg.sv
package isu_pkg;
  localparam int STAT_W = 13;
  localparam int TX_N   = 4;
  localparam int RX_N   = 5;

  localparam int B_TXTRIG  = 0;
  localparam int B_TXEMPTY = 1;
  localparam int B_TXHALF  = 2;
  localparam int B_TXFULL  = 3;
  localparam int B_RXTRIG  = 5;
  localparam int B_RXWORD  = 6;
  localparam int B_RXHALF  = 7;
  localparam int B_RXFULL  = 8;
  localparam int B_DONE    = 9;
  localparam int B_RXBYTE  = 11;
  localparam int B_ACC     = 12;

  typedef logic [STAT_W-1:0] stat_t;

  function automatic stat_t impl_mask();
    stat_t m;
    m = '0;
    m[B_TXTRIG]  = 1'b1;
    m[B_TXEMPTY] = 1'b1;
    m[B_TXHALF]  = 1'b1;
    m[B_TXFULL]  = 1'b1;
    m[B_RXTRIG]  = 1'b1;
    m[B_RXWORD]  = 1'b1;
    m[B_RXHALF]  = 1'b1;
    m[B_RXFULL]  = 1'b1;
    m[B_DONE]    = 1'b1;
    m[B_RXBYTE]  = 1'b1;
    m[B_ACC]     = 1'b1;
    return m;
  endfunction

  localparam stat_t IMPL_MASK = impl_mask();

  function automatic stat_t place_events(input logic [TX_N-1:0] tx,
                                         input logic [RX_N-1:0] rx,
                                         input logic done,
                                         input logic acc);
    stat_t v;
    v = '0;
    v[B_TXTRIG]  = tx[0];
    v[B_TXEMPTY] = tx[1];
    v[B_TXHALF]  = tx[2];
    v[B_TXFULL]  = tx[3];
    v[B_RXTRIG]  = rx[0];
    v[B_RXWORD]  = rx[1];
    v[B_RXHALF]  = rx[2];
    v[B_RXFULL]  = rx[3];
    v[B_RXBYTE]  = rx[4];
    v[B_DONE]    = done;
    v[B_ACC]     = acc;
    return v;
  endfunction

  function automatic stat_t next_status(input stat_t cur, input stat_t set,
                                        input stat_t clr);
    return ((cur & ~clr) | set) & IMPL_MASK;
  endfunction
endpackage

// File: rtl/isu_collect.sv
module isu_collect
  import isu_pkg::*;
(
  input  logic [TX_N-1:0] tx_evt_i,
  input  logic [RX_N-1:0] rx_evt_i,
  input  logic            done_evt_i,
  input  logic            acc_err_evt_i,
  output stat_t           set_vec_o
);
  assign set_vec_o = place_events(tx_evt_i, rx_evt_i, done_evt_i, acc_err_evt_i);
endmodule

// File: rtl/isu_status_reg.sv
module isu_status_reg
  import isu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  soft_clr_i,
  input  stat_t set_vec_i,
  input  logic  clr_wr_i,
  input  stat_t clr_data_i,
  output stat_t status_o
);
  stat_t status_q;
  stat_t clr_hit;

  assign clr_hit = clr_wr_i ? clr_data_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          status_q <= '0;
    else if (soft_clr_i) status_q <= '0;
    else                 status_q <= next_status(status_q, set_vec_i, clr_hit);
  end

  assign status_o = status_q;

  // R2
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_clr_i && !clr_wr_i) |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R3
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_clr_i && clr_wr_i) |=> ((status_q & $past(clr_data_i & ~set_vec_i)) == '0));

  // R5
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_clr_i |=> ((status_q & $past(set_vec_i)) == $past(set_vec_i)));

  // R11
  soft_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr_i |=> (status_q == '0));

  // R7
  reserved_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & ~IMPL_MASK) == '0);
endmodule

// File: rtl/isu_irq_gen.sv
module isu_irq_gen
  import isu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  soft_clr_i,
  input  logic  en_wr_i,
  input  stat_t en_data_i,
  input  stat_t status_i,
  output stat_t enable_o,
  output logic  irq_o
);
  stat_t enable_q;
  stat_t pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          enable_q <= '0;
    else if (soft_clr_i) enable_q <= '0;
    else if (en_wr_i)    enable_q <= en_data_i & IMPL_MASK;
  end

  assign pending  = status_i & enable_q;
  assign irq_o    = |pending;
  assign enable_o = enable_q;

  // R8
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr_i && !soft_clr_i) |=> (enable_q == $past(en_data_i & IMPL_MASK)));

  // R8
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_wr_i && !soft_clr_i) |=> $stable(enable_q));

  // R11
  soft_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr_i |=> (enable_q == '0));
endmodule

// File: rtl/isu_top.sv
module isu_top
  import isu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr_i,
  input  logic [TX_N-1:0]   tx_evt_i,
  input  logic [RX_N-1:0]   rx_evt_i,
  input  logic              done_evt_i,
  input  logic              acc_err_evt_i,
  input  logic              clr_wr_i,
  input  logic [STAT_W-1:0] clr_data_i,
  input  logic              en_wr_i,
  input  logic [STAT_W-1:0] en_data_i,
  output logic [STAT_W-1:0] status_o,
  output logic [STAT_W-1:0] enable_o,
  output logic              irq_o
);
  stat_t set_vec;

  isu_collect u_collect (
    .tx_evt_i      (tx_evt_i),
    .rx_evt_i      (rx_evt_i),
    .done_evt_i    (done_evt_i),
    .acc_err_evt_i (acc_err_evt_i),
    .set_vec_o     (set_vec)
  );

  isu_status_reg u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_clr_i (soft_clr_i),
    .set_vec_i  (set_vec),
    .clr_wr_i   (clr_wr_i),
    .clr_data_i (clr_data_i),
    .status_o   (status_o)
  );

  isu_irq_gen u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_clr_i (soft_clr_i),
    .en_wr_i    (en_wr_i),
    .en_data_i  (en_data_i),
    .status_i   (status_o),
    .enable_o   (enable_o),
    .irq_o      (irq_o)
  );
endmodule

// File: tb/tb_isu_top.sv
`timescale 1ns/1ps
module tb_isu_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_clr_i = 1'b0;
  logic [3:0]  tx_evt_i = '0;
  logic [4:0]  rx_evt_i = '0;
  logic        done_evt_i = 1'b0;
  logic        acc_err_evt_i = 1'b0;
  logic        clr_wr_i = 1'b0;
  logic [12:0] clr_data_i = '0;
  logic        en_wr_i = 1'b0;
  logic [12:0] en_data_i = '0;
  logic [12:0] status_o;
  logic [12:0] enable_o;
  logic        irq_o;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  isu_top dut (.*);

  typedef struct packed {
    logic [3:0]  tx;
    logic [4:0]  rx;
    logic        dn;
    logic        er;
    logic        cw;
    logic [12:0] cd;
    logic        ew;
    logic [12:0] ed;
    logic [12:0] xst;
    logic [12:0] xen;
    logic        xirq;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VT [NV] = '{
    '{4'b0001, 5'b00000, 1'b0, 1'b0, 1'b0, 13'h0000, 1'b0, 13'h0000, 13'h0001, 13'h0000, 1'b0},
    '{4'b0000, 5'b00001, 1'b0, 1'b0, 1'b0, 13'h0000, 1'b1, 13'h0020, 13'h0021, 13'h0020, 1'b1},
    '{4'b0000, 5'b00000, 1'b0, 1'b0, 1'b1, 13'h0001, 1'b0, 13'h0000, 13'h0020, 13'h0020, 1'b1},
    '{4'b0000, 5'b00000, 1'b0, 1'b0, 1'b1, 13'h0000, 1'b0, 13'h0000, 13'h0020, 13'h0020, 1'b1},
    '{4'b0000, 5'b00001, 1'b0, 1'b0, 1'b1, 13'h0020, 1'b0, 13'h0000, 13'h0020, 13'h0020, 1'b1},
    '{4'b0000, 5'b00000, 1'b0, 1'b0, 1'b1, 13'h0020, 1'b0, 13'h0000, 13'h0000, 13'h0020, 1'b0},
    '{4'b0000, 5'b00000, 1'b1, 1'b1, 1'b0, 13'h0000, 1'b0, 13'h0000, 13'h1200, 13'h0020, 1'b0},
    '{4'b0000, 5'b00000, 1'b0, 1'b0, 1'b0, 13'h0000, 1'b1, 13'h1000, 13'h1200, 13'h1000, 1'b1},
    '{4'b0000, 5'b00000, 1'b0, 1'b0, 1'b1, 13'h1FFF, 1'b0, 13'h0000, 13'h0000, 13'h1000, 1'b0},
    '{4'b1110, 5'b11110, 1'b0, 1'b0, 1'b0, 13'h0000, 1'b0, 13'h0000, 13'h09CE, 13'h1000, 1'b0},
    '{4'b0000, 5'b00000, 1'b0, 1'b0, 1'b0, 13'h0000, 1'b0, 13'h0000, 13'h09CE, 13'h1000, 1'b0},
    '{4'b0000, 5'b00000, 1'b0, 1'b0, 1'b0, 13'h0000, 1'b1, 13'h1FFF, 13'h09CE, 13'h1BEF, 1'b1}
  };

  task automatic chk(input string req, input logic [12:0] act, input logic [12:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    soft_clr_i = 1'b0; tx_evt_i = '0; rx_evt_i = '0; done_evt_i = 1'b0;
    acc_err_evt_i = 1'b0; clr_wr_i = 1'b0; clr_data_i = '0;
    en_wr_i = 1'b0; en_data_i = '0;
  endtask

  // Drives source k (0..10) alone; returns its expected status position.
  function automatic int src_pos(input int k);
    case (k)
      0: return 0;  1: return 1;  2: return 2;  3: return 3;
      4: return 5;  5: return 6;  6: return 7;  7: return 8;
      8: return 11; 9: return 9;  default: return 12;
    endcase
  endfunction

  task automatic drive_src(input int k);
    idle_inputs();
    if (k < 4)       tx_evt_i[k] = 1'b1;
    else if (k < 9)  rx_evt_i[k-4] = 1'b1;
    else if (k == 9) done_evt_i = 1'b1;
    else             acc_err_evt_i = 1'b1;
  endtask

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 status", status_o, 13'h0000);
    chk("R10 enable", enable_o, 13'h0000);
    chk("R10 irq", {12'h0, irq_o}, 13'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    // Table: R2 R3 R4 R5 R8 R9 R7
    for (int i = 0; i < NV; i++) begin
      tx_evt_i = VT[i].tx; rx_evt_i = VT[i].rx;
      done_evt_i = VT[i].dn; acc_err_evt_i = VT[i].er;
      clr_wr_i = VT[i].cw; clr_data_i = VT[i].cd;
      en_wr_i = VT[i].ew; en_data_i = VT[i].ed;
      @(negedge clk);
      chk("R3/R4/R5/R2 status", status_o, VT[i].xst);
      chk("R8/R7 enable", enable_o, VT[i].xen);
      chk("R9 irq", {12'h0, irq_o}, {12'h0, VT[i].xirq});
    end

    // R1 each source to its own position
    idle_inputs(); clr_wr_i = 1'b1; clr_data_i = 13'h1FFF;
    @(negedge clk);
    for (int k = 0; k < 11; k++) begin
      drive_src(k);
      @(negedge clk);
      chk("R1 position", status_o, 13'(1 << src_pos(k)));
      idle_inputs(); clr_wr_i = 1'b1; clr_data_i = 13'h1FFF;
      @(negedge clk);
      chk("R3 cleared", status_o, 13'h0000);
    end

    // R6 held condition reappears after each clear
    idle_inputs(); tx_evt_i = 4'b0010;
    @(negedge clk);
    for (int j = 0; j < 3; j++) begin
      clr_wr_i = 1'b1; clr_data_i = 13'h0002;
      @(negedge clk);
      chk("R6 held", status_o, 13'h0002);
    end
    tx_evt_i = '0;
    @(negedge clk);
    chk("R6 released", status_o, 13'h0000);

    // R11 soft clear beats strobes and writes
    idle_inputs(); acc_err_evt_i = 1'b1; en_wr_i = 1'b1; en_data_i = 13'h1000;
    @(negedge clk);
    chk("R9 irq on", {12'h0, irq_o}, 13'h0001);
    idle_inputs(); soft_clr_i = 1'b1; acc_err_evt_i = 1'b1;
    en_wr_i = 1'b1; en_data_i = 13'h1FFF;
    @(negedge clk);
    chk("R11 status", status_o, 13'h0000);
    chk("R11 enable", enable_o, 13'h0000);
    chk("R11 irq", {12'h0, irq_o}, 13'h0000);

    // R7 reserved bits of mask
    idle_inputs(); en_wr_i = 1'b1; en_data_i = 13'h0410;
    @(negedge clk);
    chk("R7 reserved mask", enable_o, 13'h0000);
    idle_inputs();
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule